// File: doc/BRIEF.md
# Clocked Byte Shifter with Bidirectional Data Line

This block moves one byte at a time over a two-wire synchronous link. The block is always the clock master. It drives a shift clock and uses one data line in both directions. A single pulse on the transmit strobe loads a byte and shifts it out. A pulse on the receive strobe instead releases the data line and collects a byte from the far end. Only one direction is active at a time.

Every bit slot lasts a fixed number of system clocks. Outgoing data changes at the start of a slot, so it is stable for a long setup interval before the shift clock rises and for a short hold interval after it. Incoming data is captured on the system clock edge that raises the shift clock, so a slow peer has as much time as possible to present its bit. When the last slot ends, the block raises a sticky completion flag and returns to idle. Requests that arrive during a transfer are dropped.

Top module: `ssp_sync_port`

## Requirements
- R1: A synchronous reset, even in the middle of a transfer, returns the port to idle on the next clock edge: shift clock high, output enable low, completion flag low, received byte 0x00.
- R2: A transmit strobe seen while idle starts a transfer on that edge. From the next cycle the output enable is high and the completion flag is low.
- R3: A bit slot is 12 clocks, numbered 0..11 from the edge that starts the slot. The shift clock is low in slots 4..9 and high in the others. A transfer has exactly 8 slots and so exactly 8 rising edges of the shift clock.
- R4: Transmitted bits go least significant first. Bit k appears in the first cycle of slot k and holds through slot 11 of that bit. This gives 10 clocks of setup and 2 clocks of hold around the rising shift-clock edge.
- R5: A receive strobe seen while idle starts a receive transfer with the output enable low. The data input is sampled on the clock edge that raises the shift clock and nowhere else. Received bits are assembled least significant first. The received-byte output changes only on the edge that ends a receive transfer.
- R6: The completion flag rises on the edge that ends the eighth slot, 2 clocks after the eighth rising edge. It stays high until the next accepted request.
- R7: Transmit or receive strobes that arrive while a transfer is in progress are ignored. The running transfer still makes exactly 8 rising edges and keeps its data.
- R8: If both strobes arrive in the same idle cycle, the transmit strobe wins.
- R9: While idle, the shift clock is high, the output enable is low and the data output rests at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; one bit slot spans 12 of its periods |
| rst_i | input | 1 | Synchronous reset, active high |
| tx_wr_i | input | 1 | Transmit strobe; loads tx_data_i when idle |
| tx_data_i | input | 8 | Byte to transmit |
| rx_en_i | input | 1 | Receive strobe; starts a receive when idle |
| sd_i | input | 1 | Data line as seen at the pad |
| sd_o | output | 1 | Data line drive value |
| sd_oe_o | output | 1 | Data line output enable (high while transmitting) |
| sclk_o | output | 1 | Shift clock, idles high |
| rx_data_o | output | 8 | Last byte received |
| done_o | output | 1 | Sticky completion flag |

## Verification
The bench builds the port with its default parameters: an 8-bit word, a 12-clock slot, a 10-clock setup interval and a 6-clock low phase. With these values every slot position and the 96-clock transfer length can be reached many times in a short run. The reference model predicts every output on every cycle. During receives it presents the correct bit only in the cycle just before the rising shift-clock edge and the inverted bit in all other cycles, so a capture one cycle early or late is caught. Dropped requests, the strobe collision, back-to-back restarts and a reset in mid-transfer are all driven within the same short run.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

   // Transfer direction held by the controller
   typedef enum logic [1:0] {
      SSP_IDLE = 2'd0,
      SSP_TX   = 2'd1,
      SSP_RX   = 2'd2
   } ssp_mode_e;

endpackage

// File: rtl/ssp_timing.sv
// Slot and bit counters; derives the shift clock and the strobes
// that tell the shifter when to capture and when to advance.
module ssp_timing #(
   parameter int unsigned BIT_CLKS   = 12,
   parameter int unsigned SETUP_CLKS = 10,
   parameter int unsigned LOW_CLKS   = 6,
   parameter int unsigned NBITS      = 8
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic run_i,
   output logic sclk_o,
   output logic sample_o,
   output logic wrap_o,
   output logic last_o
);

   localparam int unsigned PH_W    = $clog2(BIT_CLKS);
   localparam int unsigned BT_W    = $clog2(NBITS);
   localparam int unsigned RISE_PH = SETUP_CLKS;
   localparam int unsigned FALL_PH = SETUP_CLKS - LOW_CLKS;
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(BIT_CLKS - 1);
   localparam logic [PH_W-1:0] PH_RISE = PH_W'(RISE_PH);
   localparam logic [PH_W-1:0] PH_FALL = PH_W'(FALL_PH);
   localparam logic [PH_W-1:0] PH_SAMP = PH_W'(RISE_PH - 1);
   localparam logic [BT_W-1:0] BT_LAST = BT_W'(NBITS - 1);

   // Elaboration-time parameter checks
   if (BIT_CLKS < 3) begin : g_err_bitclks
      $error("ssp_timing: BIT_CLKS must be at least 3");
   end
   if (SETUP_CLKS >= BIT_CLKS || SETUP_CLKS < 2) begin : g_err_setup
      $error("ssp_timing: SETUP_CLKS must lie in 2..BIT_CLKS-1");
   end
   if (LOW_CLKS < 1 || LOW_CLKS >= SETUP_CLKS) begin : g_err_low
      $error("ssp_timing: LOW_CLKS must lie in 1..SETUP_CLKS-1");
   end
   if (NBITS < 2) begin : g_err_nbits
      $error("ssp_timing: NBITS must be at least 2");
   end

   logic [PH_W-1:0] ph_q;
   logic [BT_W-1:0] bt_q;

   always_ff @(posedge clk_i) begin
      if (rst_i || !run_i) begin
         ph_q <= '0;
         bt_q <= '0;
      end else if (ph_q == PH_LAST) begin
         ph_q <= '0;
         bt_q <= last_o ? '0 : bt_q + 1'b1;
      end else begin
         ph_q <= ph_q + 1'b1;
      end
   end

   assign sclk_o   = !(run_i && (ph_q >= PH_FALL) && (ph_q < PH_RISE));
   assign sample_o = run_i && (ph_q == PH_SAMP);
   assign wrap_o   = run_i && (ph_q == PH_LAST);
   assign last_o   = (bt_q == BT_LAST);

   // The capture strobe must coincide with the rising clock edge
   AST_SAMPLE_AT_RISE: assert property (@(posedge clk_i) disable iff (rst_i)
      sample_o |=> $rose(sclk_o)); // R5

   // Clock is high when a slot closes, so the hold interval lies in the high phase
   AST_HIGH_AT_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
      wrap_o |-> sclk_o); // R4

   if (LOW_CLKS > 1) begin : g_low_chk
      AST_LOW_WIDTH: assert property (@(posedge clk_i) disable iff (rst_i)
         $fell(sclk_o) |=> !sclk_o); // R3
   end

endmodule

// File: rtl/ssp_shifter.sv
// Data shift register; bit order chosen at elaboration.
module ssp_shifter #(
   parameter int unsigned NBITS     = 8,
   parameter bit          LSB_FIRST = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             load_i,
   input  logic [NBITS-1:0] load_val_i,
   input  logic             clr_i,
   input  logic             adv_i,
   input  logic             cap_i,
   input  logic             sd_i,
   output logic             out_bit_o,
   output logic [NBITS-1:0] word_o
);

   logic [NBITS-1:0] sh_q;
   logic [NBITS-1:0] sh_adv;
   logic [NBITS-1:0] sh_cap;

   if (LSB_FIRST) begin : g_lsb
      assign sh_adv    = {1'b0, sh_q[NBITS-1:1]};
      assign sh_cap    = {sd_i, sh_q[NBITS-1:1]};
      assign out_bit_o = sh_q[0];
   end else begin : g_msb
      assign sh_adv    = {sh_q[NBITS-2:0], 1'b0};
      assign sh_cap    = {sh_q[NBITS-2:0], sd_i};
      assign out_bit_o = sh_q[NBITS-1];
   end

   always_ff @(posedge clk_i) begin
      if (rst_i || clr_i) begin
         sh_q <= '0;
      end else if (load_i) begin
         sh_q <= load_val_i;
      end else if (cap_i) begin
         sh_q <= sh_cap;
      end else if (adv_i) begin
         sh_q <= sh_adv;
      end
   end

   assign word_o = sh_q;

   // Load, capture and advance come from exclusive controller states
   AST_ONE_SHIFT_OP: assert property (@(posedge clk_i) disable iff (rst_i)
      $onehot0({load_i, clr_i, cap_i, adv_i})); // R7

endmodule

// File: rtl/ssp_ctrl.sv
// Direction state, request arbitration and the sticky completion flag.
module ssp_ctrl
   import ssp_pkg::*;
(
   input  logic      clk_i,
   input  logic      rst_i,
   input  logic      tx_req_i,
   input  logic      rx_req_i,
   input  logic      wrap_i,
   input  logic      last_i,
   output ssp_mode_e mode_o,
   output logic      done_o,
   output logic      start_tx_o,
   output logic      start_rx_o,
   output logic      finish_o
);

   ssp_mode_e mode_q;
   logic      done_q;

   assign start_tx_o = (mode_q == SSP_IDLE) && tx_req_i;
   assign start_rx_o = (mode_q == SSP_IDLE) && rx_req_i && !tx_req_i;
   assign finish_o   = (mode_q != SSP_IDLE) && wrap_i && last_i;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         mode_q <= SSP_IDLE;
         done_q <= 1'b0;
      end else if (start_tx_o) begin
         mode_q <= SSP_TX;
         done_q <= 1'b0;
      end else if (start_rx_o) begin
         mode_q <= SSP_RX;
         done_q <= 1'b0;
      end else if (finish_o) begin
         mode_q <= SSP_IDLE;
         done_q <= 1'b1;
      end
   end

   assign mode_o = mode_q;
   assign done_o = done_q;

   AST_REQ_IGNORED: assert property (@(posedge clk_i) disable iff (rst_i)
      (mode_q != SSP_IDLE && !finish_o) |=> (mode_q == $past(mode_q))); // R7

   AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
      (done_q && mode_q == SSP_IDLE && !tx_req_i && !rx_req_i) |=> done_q); // R6

   AST_DONE_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
      (start_tx_o || start_rx_o) |=> !done_q); // R2

   AST_TX_WINS: assert property (@(posedge clk_i) disable iff (rst_i)
      (mode_q == SSP_IDLE && tx_req_i && rx_req_i) |=> (mode_q == SSP_TX)); // R8

endmodule

// File: rtl/ssp_sync_port.sv
// Top: synchronous byte shifter with a shared data line.
module ssp_sync_port
   import ssp_pkg::*;
#(
   parameter int unsigned NBITS      = 8,
   parameter int unsigned BIT_CLKS   = 12,
   parameter int unsigned SETUP_CLKS = 10,
   parameter int unsigned LOW_CLKS   = 6,
   parameter bit          LSB_FIRST  = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             tx_wr_i,
   input  logic [NBITS-1:0] tx_data_i,
   input  logic             rx_en_i,
   input  logic             sd_i,
   output logic             sd_o,
   output logic             sd_oe_o,
   output logic             sclk_o,
   output logic [NBITS-1:0] rx_data_o,
   output logic             done_o
);

   ssp_mode_e        mode_w;
   logic             start_tx_w, start_rx_w, finish_w;
   logic             sample_w, wrap_w, last_w;
   logic             out_bit_w;
   logic [NBITS-1:0] word_w;
   logic [NBITS-1:0] rx_q;
   logic             running_w;

   assign running_w = (mode_w != SSP_IDLE);

   ssp_ctrl i_ctrl (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .tx_req_i   (tx_wr_i),
      .rx_req_i   (rx_en_i),
      .wrap_i     (wrap_w),
      .last_i     (last_w),
      .mode_o     (mode_w),
      .done_o     (done_o),
      .start_tx_o (start_tx_w),
      .start_rx_o (start_rx_w),
      .finish_o   (finish_w)
   );

   ssp_timing #(
      .BIT_CLKS   (BIT_CLKS),
      .SETUP_CLKS (SETUP_CLKS),
      .LOW_CLKS   (LOW_CLKS),
      .NBITS      (NBITS)
   ) i_timing (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .run_i    (running_w),
      .sclk_o   (sclk_o),
      .sample_o (sample_w),
      .wrap_o   (wrap_w),
      .last_o   (last_w)
   );

   ssp_shifter #(
      .NBITS     (NBITS),
      .LSB_FIRST (LSB_FIRST)
   ) i_shifter (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .load_i     (start_tx_w),
      .load_val_i (tx_data_i),
      .clr_i      (start_rx_w),
      .adv_i      (mode_w == SSP_TX && wrap_w && !last_w),
      .cap_i      (mode_w == SSP_RX && sample_w),
      .sd_i       (sd_i),
      .out_bit_o  (out_bit_w),
      .word_o     (word_w)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         rx_q <= '0;
      end else if (finish_w && mode_w == SSP_RX) begin
         rx_q <= word_w;
      end
   end

   assign sd_oe_o   = (mode_w == SSP_TX);
   assign sd_o      = sd_oe_o ? out_bit_w : 1'b1;
   assign rx_data_o = rx_q;

   AST_IDLE_LINES: assert property (@(posedge clk_i) disable iff (rst_i)
      (mode_w == SSP_IDLE) |-> (sclk_o && !sd_oe_o && sd_o)); // R9

   AST_TX_DATA_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
      (sd_oe_o && !$rose(sd_oe_o) && !$past(wrap_w)) |-> $stable(sd_o)); // R4

   AST_RXDATA_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
      !finish_w |=> $stable(rx_data_o)); // R5

endmodule

// File: tb/test_ssp_sync_port.sv
`timescale 1ns/1ps
module test_ssp_sync_port;

   localparam int NB   = 8;
   localparam int SLOT = 12;
   localparam int LO_A = 4;   // first low slot position
   localparam int HI_B = 10;  // position where the clock rises

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          tx_wr = 1'b0;
   logic [NB-1:0] tx_data = '0;
   logic          rx_en = 1'b0;
   logic          sd_in = 1'b0;
   logic          sd_o, sd_oe, sclk, done;
   logic [NB-1:0] rx_data;

   always #2 clk = ~clk;

   ssp_sync_port i_ssp_sync_port (
      .clk_i     (clk),
      .rst_i     (rst),
      .tx_wr_i   (tx_wr),
      .tx_data_i (tx_data),
      .rx_en_i   (rx_en),
      .sd_i      (sd_in),
      .sd_o      (sd_o),
      .sd_oe_o   (sd_oe),
      .sclk_o    (sclk),
      .rx_data_o (rx_data),
      .done_o    (done)
   );

   // Behavioural reference: 0 idle, 1 sending, 2 receiving
   int          m_state = 0;
   int          m_cnt   = 0;
   bit          m_done  = 1'b0;
   bit [NB-1:0] m_byte  = '0;
   bit [NB-1:0] m_acc   = '0;
   bit [NB-1:0] m_rxd   = '0;
   bit [NB-1:0] rx_pat  = '0;

   int n_chk  = 0;
   int n_fail = 0;
   int rises  = 0;
   bit prev_sclk = 1'b1;
   bit finished  = 1'b0;

   always @(posedge clk) begin
      if (rst) begin
         m_state = 0; m_cnt = 0; m_done = 1'b0; m_rxd = '0;
      end else if (m_state == 0) begin
         if (tx_wr) begin
            m_state = 1; m_cnt = 0; m_byte = tx_data; m_done = 1'b0;
         end else if (rx_en) begin
            m_state = 2; m_cnt = 0; m_acc = '0; m_done = 1'b0;
         end
      end else begin
         if (m_state == 2 && (m_cnt % SLOT) == HI_B - 1)
            m_acc[m_cnt / SLOT] = sd_in;
         if (m_cnt == NB * SLOT - 1) begin
            if (m_state == 2) m_rxd = m_acc;
            m_state = 0; m_cnt = 0; m_done = 1'b1;
         end else begin
            m_cnt++;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      int  ph;
      bit  e_sclk, e_sd;
      ph     = m_cnt % SLOT;
      e_sclk = !(m_state != 0 && ph >= LO_A && ph < HI_B);
      e_sd   = (m_state == 1) ? m_byte[m_cnt / SLOT] : 1'b1;
      chk(sclk == e_sclk, (m_state == 0) ? "R9 idle clock" : "R3 clock shape", int'(sclk), int'(e_sclk));
      chk(sd_oe == (m_state == 1), "R2 output enable", int'(sd_oe), int'(m_state == 1));
      chk(sd_o == e_sd, (m_state == 1) ? "R4 tx bit" : "R9 idle data", int'(sd_o), int'(e_sd));
      chk(done == m_done, "R6 completion flag", int'(done), int'(m_done));
      chk(rx_data == m_rxd, "R5 received byte", int'(rx_data), int'(m_rxd));
   endtask

   // One clock: model and design advance at posedge, compare at negedge
   task automatic step();
      int ph;
      @(negedge clk);
      compare_all();
      if (!prev_sclk && sclk) rises++;
      prev_sclk = sclk;
      ph = m_cnt % SLOT;
      if (m_state == 2) begin
         // correct bit only in the cycle before the rising edge
         sd_in = (ph == HI_B - 1) ? rx_pat[m_cnt / SLOT] : ~rx_pat[m_cnt / SLOT];
      end else begin
         sd_in = 1'b0;
      end
   endtask

   task automatic start_tx(input bit [NB-1:0] d);
      tx_wr = 1'b1; tx_data = d; rises = 0;
      step();
      tx_wr = 1'b0;
   endtask

   task automatic start_rx(input bit [NB-1:0] p);
      rx_pat = p; rx_en = 1'b1; rises = 0;
      step();
      rx_en = 1'b0;
   endtask

   task automatic finish_xfer();
      for (int i = 0; i < 200 && m_state != 0; i++) step();
   endtask

   initial begin
      @(posedge clk);
      @(posedge clk);
      step();
      rst = 1'b0;
      // R1 reset state
      chk(sclk == 1'b1, "R1 clock after reset", int'(sclk), 1);
      chk(sd_oe == 1'b0, "R1 enable after reset", int'(sd_oe), 0);
      chk(done == 1'b0, "R1 flag after reset", int'(done), 0);
      chk(rx_data == '0, "R1 byte after reset", int'(rx_data), 0);
      for (int i = 0; i < 5; i++) step();

      // plain transmit
      start_tx(8'hA5);
      finish_xfer();
      chk(rises == 8, "R3 rising edges per transfer", rises, 8);
      chk(done == 1'b1, "R6 flag at end", int'(done), 1);
      for (int i = 0; i < 20; i++) step();
      chk(done == 1'b1, "R6 flag sticky", int'(done), 1);

      // transmit with stray requests mid-transfer
      start_tx(8'h01);
      for (int i = 0; i < 30; i++) step();
      tx_wr = 1'b1; tx_data = 8'hFF;
      step();
      tx_wr = 1'b0; rx_en = 1'b1;
      for (int i = 0; i < 20; i++) step();
      rx_en = 1'b0;
      finish_xfer();
      chk(rises == 8, "R7 edges with ignored requests", rises, 8);
      chk(done == 1'b1, "R7 transfer completed", int'(done), 1);

      // receives
      start_rx(8'h6B);
      chk(sd_oe == 1'b0, "R5 line released", int'(sd_oe), 0);
      finish_xfer();
      chk(rx_data == 8'h6B, "R5 byte 6B", int'(rx_data), 'h6B);
      step();
      start_rx(8'h80);
      finish_xfer();
      chk(rx_data == 8'h80, "R5 byte 80", int'(rx_data), 'h80);

      // both strobes together
      step();
      tx_wr = 1'b1; rx_en = 1'b1; tx_data = 8'h5A; rises = 0;
      step();
      tx_wr = 1'b0; rx_en = 1'b0;
      chk(sd_oe == 1'b1, "R8 transmit wins", int'(sd_oe), 1);
      finish_xfer();
      chk(rx_data == 8'h80, "R8 receive byte untouched", int'(rx_data), 'h80);

      // back-to-back restart clears the flag
      start_tx(8'hC3);
      chk(done == 1'b0, "R2 flag cleared on start", int'(done), 0);
      finish_xfer();

      // reset in mid-transfer
      start_rx(8'hFF);
      for (int i = 0; i < 20; i++) step();
      rst = 1'b1;
      step();
      rst = 1'b0;
      chk(sclk == 1'b1 && sd_oe == 1'b0, "R1 mid-transfer reset lines", int'({sclk, sd_oe}), 2);
      chk(done == 1'b0 && rx_data == '0, "R1 mid-transfer reset state", int'({done, rx_data}), 0);
      for (int i = 0; i < 10; i++) step();

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule